// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns the operand fields of a load or store into the memory address it should use. A 3-bit mode select picks one of eight ways to combine a base register, an index register, the program counter, a width-selectable displacement, a full-width PC offset and a 2-bit scale. For the two modes that update their base register, the unit also produces the value to write back and an enable for that write.

Seven of the modes are pure combinational arithmetic. For these, the done strobe rises in the same cycle as the request. The memory-indirect mode takes two steps. First the unit issues a pointer read at the base address over a request/acknowledge handshake. It then uses the returned word as the final address and pulses done in the cycle the acknowledge arrives. While that read is outstanding, new requests are ignored.

Top module: `agu_top`

## Requirements
- R1: Mode code 0 (register indirect): ea_o equals base_i, done_o is high in the same cycle as req_i, and wb_en_o stays low.
- R2: Mode code 1 (displacement): ea_o = base_i + sign-extended displacement. disp_sel_i selects the displacement width: 0 means 8 bits, 1 means 16 bits, and 2 or 3 means 32 bits. Bits of disp_i above the selected width have no effect.
- R3: Mode code 2 (index plus base): ea_o = base_i + index_i, modulo 2^32.
- R4: Mode code 3 (scaled): ea_o = base_i + (index_i << scale_i) + sign-extended displacement, so scale_i values 0..3 multiply the index by 1, 2, 4 or 8. scale_i has no effect in any other mode.
- R5: Mode code 4 (PC relative): ea_o = pc_i + pc_off_i, modulo 2^32.
- R6: Mode code 5 (auto-increment): ea_o = base_i, wb_en_o is high with done_o, and wb_val_o = base_i + 1 modulo 2^32.
- R7: Mode code 6 (auto-indexing): ea_o = base_i + sign-extended displacement, wb_en_o is high with done_o, and wb_val_o equals ea_o.
- R8: Mode code 7 (memory indirect): done_o is low in the request cycle. From the next cycle, ptr_req_o is high and ptr_addr_o holds the base_i value sampled with the request, unchanged, until ptr_ack_i. In the acknowledge cycle, done_o is high, ea_o equals ptr_data_i, and wb_en_o is low.
- R9: done_o is a single-cycle pulse for each completed request. After a pointer acknowledge, ptr_req_o and done_o are low in the next cycle unless a new request arrives.
- R10: While a pointer read is outstanding, req_i is ignored: no done_o, no wb_en_o, and ptr_addr_o does not change.
- R11: While rst_ni is low, ptr_req_o is low, and a pending pointer read is abandoned at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Address request |
| mode_i | input | 3 | Addressing mode code |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| pc_i | input | 32 | Program counter |
| disp_i | input | 32 | Displacement immediate (width per disp_sel_i) |
| disp_sel_i | input | 2 | Displacement width select |
| pc_off_i | input | 32 | PC-relative offset immediate |
| scale_i | input | 2 | Index scale as a shift of 0..3 |
| ptr_req_o | output | 1 | Pointer read request |
| ptr_addr_o | output | 32 | Pointer read address |
| ptr_ack_i | input | 1 | Pointer read acknowledge |
| ptr_data_i | input | 32 | Pointer read data |
| ea_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base writeback enable |
| wb_val_o | output | 32 | Base writeback value |
| done_o | output | 1 | Address valid strobe |

## Verification
The combinational modes are driven from a vector table. It includes negative 8-bit and 16-bit displacements, which tell sign extension apart from zero extension. It includes set bits above the chosen width, which show that masking happens before the add. Every scale value is used, so a wrong shift amount gives a distinct result, and a base of all ones shows that the auto-increment writeback wraps. Directed sequences exercise the memory-indirect handshake with a delayed and an immediate acknowledge. They also cover a competing request and a base change during the wait, and a reset while a pointer read is pending. These cases separate a held pointer address from a live one, and a single done pulse from a repeated one.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_REG  = 3'd0,
    AM_DISP = 3'd1,
    AM_IDX  = 3'd2,
    AM_SCL  = 3'd3,
    AM_PCR  = 3'd4,
    AM_AINC = 3'd5,
    AM_AIDX = 3'd6,
    AM_MIND = 3'd7
  } amode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ind_state_e;
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
  parameter int OUT_W    = 32,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16
) (
  input  logic [OUT_W-1:0] raw_i,
  input  logic [1:0]       sel_i,
  output logic [OUT_W-1:0] ext_o
);
  localparam int NARROW_PAD = OUT_W - NARROW_W;
  localparam int MID_PAD    = OUT_W - MID_W;

  logic [OUT_W-1:0] narrow_ext, mid_ext;

  assign narrow_ext = {{NARROW_PAD{raw_i[NARROW_W-1]}}, raw_i[NARROW_W-1:0]};
  assign mid_ext    = {{MID_PAD{raw_i[MID_W-1]}}, raw_i[MID_W-1:0]};

  always_comb begin
    unique case (sel_i)
      2'd0:    ext_o = narrow_ext;
      2'd1:    ext_o = mid_ext;
      default: ext_o = raw_i;
    endcase
  end
endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SCALE_W = 2
) (
  input  amode_e             mode_i,
  input  logic [AW-1:0]      base_i,
  input  logic [AW-1:0]      index_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [AW-1:0]      disp_ext_i,
  input  logic [AW-1:0]      pc_off_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [AW-1:0]      ea_o,
  output logic [AW-1:0]      wb_val_o,
  output logic               wb_mode_o
);
  logic [AW-1:0] scaled_idx, base_disp, base_idx, scl_sum, base_inc;

  assign scaled_idx = index_i << scale_i;
  assign base_disp  = base_i + disp_ext_i;
  assign base_idx   = base_i + index_i;
  assign scl_sum    = base_i + scaled_idx + disp_ext_i;
  assign base_inc   = base_i + {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    ea_o      = base_i;
    wb_val_o  = base_i;
    wb_mode_o = 1'b0;
    unique case (mode_i)
      AM_REG:  ea_o = base_i;
      AM_DISP: ea_o = base_disp;
      AM_IDX:  ea_o = base_idx;
      AM_SCL:  ea_o = scl_sum;
      AM_PCR:  ea_o = pc_i + pc_off_i;
      AM_AINC: begin
        ea_o      = base_i;
        wb_val_o  = base_inc;
        wb_mode_o = 1'b1;
      end
      AM_AIDX: begin
        ea_o      = base_disp;
        wb_val_o  = base_disp;
        wb_mode_o = 1'b1;
      end
      default: ea_o = base_i;
    endcase
  end
endmodule

// File: rtl/agu_ind_fsm.sv
module agu_ind_fsm
  import agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic          ptr_ack_i,
  output logic          ptr_req_o,
  output logic [AW-1:0] ptr_addr_o,
  output logic          busy_o,
  output logic          fin_o
);
  ind_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)   state_d = ST_WAIT;
      ST_WAIT: if (ptr_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) addr_q <= base_i;
    end
  end

  assign busy_o     = (state_q == ST_WAIT);
  assign ptr_req_o  = busy_o;
  assign ptr_addr_o = addr_q;
  assign fin_o      = busy_o && ptr_ack_i;

  // R8
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_req_o && !ptr_ack_i |=> ptr_req_o && $stable(ptr_addr_o));

  // R8
  ptr_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> ptr_req_o && ptr_addr_o == $past(base_i));

  // R9
  ptr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_req_o && ptr_ack_i |=> !ptr_req_o);
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SCALE_W  = 2,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [2:0]         mode_i,
  input  logic [AW-1:0]      base_i,
  input  logic [AW-1:0]      index_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [AW-1:0]      disp_i,
  input  logic [1:0]         disp_sel_i,
  input  logic [AW-1:0]      pc_off_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               ptr_req_o,
  output logic [AW-1:0]      ptr_addr_o,
  input  logic               ptr_ack_i,
  input  logic [AW-1:0]      ptr_data_i,
  output logic [AW-1:0]      ea_o,
  output logic               wb_en_o,
  output logic [AW-1:0]      wb_val_o,
  output logic               done_o
);
  amode_e        mode;
  logic [AW-1:0] disp_ext, dp_ea;
  logic          wb_mode, busy, fin, start_ind, single_done;

  assign mode = amode_e'(mode_i);

  agu_disp_ext #(.OUT_W(AW), .NARROW_W(NARROW_W), .MID_W(MID_W)) u_ext (
    .raw_i (disp_i),
    .sel_i (disp_sel_i),
    .ext_o (disp_ext)
  );

  agu_datapath #(.AW(AW), .SCALE_W(SCALE_W)) u_dp (
    .mode_i     (mode),
    .base_i     (base_i),
    .index_i    (index_i),
    .pc_i       (pc_i),
    .disp_ext_i (disp_ext),
    .pc_off_i   (pc_off_i),
    .scale_i    (scale_i),
    .ea_o       (dp_ea),
    .wb_val_o   (wb_val_o),
    .wb_mode_o  (wb_mode)
  );

  assign start_ind   = req_i && (mode == AM_MIND) && !busy;
  assign single_done = req_i && (mode != AM_MIND) && !busy;

  agu_ind_fsm #(.AW(AW)) u_ind (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_ind),
    .base_i     (base_i),
    .ptr_ack_i  (ptr_ack_i),
    .ptr_req_o  (ptr_req_o),
    .ptr_addr_o (ptr_addr_o),
    .busy_o     (busy),
    .fin_o      (fin)
  );

  assign ea_o    = busy ? ptr_data_i : dp_ea;
  assign done_o  = single_done || fin;
  assign wb_en_o = single_done && wb_mode;

  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_req_o && !ptr_ack_i |-> !done_o && !wb_en_o);

  // R1
  regind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ptr_req_o && mode_i == 3'd0 |-> done_o && ea_o == base_i && !wb_en_o);

  // R6
  autoinc_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o && mode_i == 3'd5 |-> wb_val_o == ea_o + 32'd1);

  // R7
  autoidx_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o && mode_i == 3'd6 |-> wb_val_o == ea_o);

  // R8
  ind_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ptr_req_o && mode_i == 3'd7 |-> !done_o);

  // R8
  ind_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_req_o && ptr_ack_i |-> done_o && ea_o == ptr_data_i && !wb_en_o);
endmodule

// File: tb/agu_top_tb_top.sv
module agu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] base = '0, index = '0, pc = '0, disp = '0, pc_off = '0, ptr_data = '0;
  logic [1:0]  dsel = '0, scale = '0;
  logic        ptr_ack = 1'b0;
  logic        ptr_req, wb_en, done;
  logic [31:0] ptr_addr, ea, wb_val;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  agu_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode),
    .base_i(base), .index_i(index), .pc_i(pc), .disp_i(disp),
    .disp_sel_i(dsel), .pc_off_i(pc_off), .scale_i(scale),
    .ptr_req_o(ptr_req), .ptr_addr_o(ptr_addr), .ptr_ack_i(ptr_ack),
    .ptr_data_i(ptr_data), .ea_o(ea), .wb_en_o(wb_en), .wb_val_o(wb_val),
    .done_o(done)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [31:0] base;
    logic [31:0] index;
    logic [31:0] pc;
    logic [31:0] disp;
    logic [1:0]  dsel;
    logic [31:0] pc_off;
    logic [1:0]  scale;
    logic [31:0] ea;
    logic        wb_en;
    logic [31:0] wb_val;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 32'h0000_1000, 32'h0,  32'h0,      32'h0000_0000, 2'd0, 32'h0,         2'd0, 32'h0000_1000, 1'b0, 32'h0},
    '{3'd1, 32'h0000_1000, 32'h0,  32'h0,      32'h0000_00F0, 2'd0, 32'h0,         2'd0, 32'h0000_0FF0, 1'b0, 32'h0},
    '{3'd1, 32'h0000_1000, 32'h0,  32'h0,      32'h0000_8000, 2'd1, 32'h0,         2'd0, 32'hFFFF_9000, 1'b0, 32'h0},
    '{3'd1, 32'h0000_1000, 32'h0,  32'h0,      32'h1234_5678, 2'd2, 32'h0,         2'd0, 32'h1234_6678, 1'b0, 32'h0},
    '{3'd1, 32'h0000_1000, 32'h0,  32'h0,      32'h0000_017F, 2'd0, 32'h0,         2'd0, 32'h0000_107F, 1'b0, 32'h0},
    '{3'd2, 32'h0000_2000, 32'h30, 32'h0,      32'h0000_0000, 2'd0, 32'h0,         2'd3, 32'h0000_2030, 1'b0, 32'h0},
    '{3'd3, 32'h0000_0100, 32'h3,  32'h0,      32'h0000_0004, 2'd0, 32'h0,         2'd0, 32'h0000_0107, 1'b0, 32'h0},
    '{3'd3, 32'h0000_0100, 32'h3,  32'h0,      32'h0000_0004, 2'd0, 32'h0,         2'd1, 32'h0000_010A, 1'b0, 32'h0},
    '{3'd3, 32'h0000_0100, 32'h3,  32'h0,      32'h0000_0004, 2'd0, 32'h0,         2'd2, 32'h0000_0110, 1'b0, 32'h0},
    '{3'd3, 32'h0000_0100, 32'h3,  32'h0,      32'h0000_00FC, 2'd0, 32'h0,         2'd3, 32'h0000_0114, 1'b0, 32'h0},
    '{3'd4, 32'h0,         32'h0,  32'h4000,   32'h0000_0000, 2'd0, 32'hFFFF_FFF8, 2'd2, 32'h0000_3FF8, 1'b0, 32'h0},
    '{3'd5, 32'h0000_5000, 32'h0,  32'h0,      32'h0000_0000, 2'd0, 32'h0,         2'd0, 32'h0000_5000, 1'b1, 32'h0000_5001},
    '{3'd5, 32'hFFFF_FFFF, 32'h0,  32'h0,      32'h0000_0000, 2'd0, 32'h0,         2'd0, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000},
    '{3'd6, 32'h0000_6000, 32'h0,  32'h0,      32'h0000_0010, 2'd0, 32'h0,         2'd0, 32'h0000_6010, 1'b1, 32'h0000_6010},
    '{3'd6, 32'h0000_6000, 32'h0,  32'h0,      32'h0000_FFF0, 2'd1, 32'h0,         2'd0, 32'h0000_5FF0, 1'b1, 32'h0000_5FF0}
  };

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (2) @(negedge clk);
    check("R11 ptr_req in reset", {31'b0, ptr_req}, 32'd0);
    check("R11 done in reset", {31'b0, done}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      req = 1'b1; mode = VECS[i].mode; base = VECS[i].base; index = VECS[i].index;
      pc = VECS[i].pc; disp = VECS[i].disp; dsel = VECS[i].dsel;
      pc_off = VECS[i].pc_off; scale = VECS[i].scale;
      #2;
      check({tag_of(VECS[i].mode), " ea"}, ea, VECS[i].ea);
      check({tag_of(VECS[i].mode), " done"}, {31'b0, done}, 32'd1);
      check({tag_of(VECS[i].mode), " wb_en"}, {31'b0, wb_en}, {31'b0, VECS[i].wb_en});
      if (VECS[i].wb_en) check({tag_of(VECS[i].mode), " wb_val"}, wb_val, VECS[i].wb_val);
    end
    @(negedge clk);
    req = 1'b0;
    #2 check("R9 done idle", {31'b0, done}, 32'd0);

    // R8 delayed acknowledge, with R10 competing request
    @(negedge clk);
    req = 1'b1; mode = 3'd7; base = 32'h0000_0080;
    #2 check("R8 no done on request", {31'b0, done}, 32'd0);
    @(negedge clk);
    req = 1'b1; mode = 3'd1; base = 32'h0000_0999; disp = 32'h4; dsel = 2'd0;
    #2;
    check("R8 ptr_req raised", {31'b0, ptr_req}, 32'd1);
    check("R8 ptr_addr", ptr_addr, 32'h0000_0080);
    check("R10 done ignored", {31'b0, done}, 32'd0);
    check("R10 wb ignored", {31'b0, wb_en}, 32'd0);
    @(negedge clk);
    req = 1'b1; mode = 3'd5;
    #2;
    check("R10 ptr_addr held", ptr_addr, 32'h0000_0080);
    check("R10 autoinc ignored", {31'b0, wb_en}, 32'd0);
    @(negedge clk);
    req = 1'b0; ptr_ack = 1'b1; ptr_data = 32'hCAFE_0000;
    #2;
    check("R8 done on ack", {31'b0, done}, 32'd1);
    check("R8 ea from pointer", ea, 32'hCAFE_0000);
    check("R8 no writeback", {31'b0, wb_en}, 32'd0);
    @(negedge clk);
    ptr_ack = 1'b0;
    #2;
    check("R9 done single pulse", {31'b0, done}, 32'd0);
    check("R9 ptr_req dropped", {31'b0, ptr_req}, 32'd0);

    // R8 immediate acknowledge
    @(negedge clk);
    req = 1'b1; mode = 3'd7; base = 32'h0000_0040;
    @(negedge clk);
    req = 1'b0; ptr_ack = 1'b1; ptr_data = 32'h0000_1234;
    #2;
    check("R8 fast ptr_addr", ptr_addr, 32'h0000_0040);
    check("R8 fast done", {31'b0, done}, 32'd1);
    check("R8 fast ea", ea, 32'h0000_1234);
    @(negedge clk);
    ptr_ack = 1'b0;
    #2 check("R9 fast ptr_req dropped", {31'b0, ptr_req}, 32'd0);

    // R11 reset abandons pending pointer read
    @(negedge clk);
    req = 1'b1; mode = 3'd7; base = 32'h0000_0200;
    @(negedge clk);
    req = 1'b0;
    #2 check("R11 pending before reset", {31'b0, ptr_req}, 32'd1);
    rst_n = 1'b0;
    #1 check("R11 ptr_req cleared", {31'b0, ptr_req}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2 check("R11 stays idle", {31'b0, ptr_req}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule